// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block makes a 512-byte array look like a serial EEPROM on an SPI bus run in mode 0. It oversamples chip select, serial clock, serial input, pause and write-guard pins in the system clock domain. Each input passes through a two-flop synchroniser and then an edge detector. The block decodes the one-byte command that opens every transaction and serves array reads through a combinational read port. It collects page-write bytes in an eight-entry buffer. Status reads return a byte supplied by a companion controller.

Anything that changes stored state leaves the block as a request. Such requests are: setting or clearing the write-enable latch, writing the status byte, or programming a page. The companion controller owns the enable latch, block protection, the write timer and the array itself. It takes a request in a valid/ready handshake and reports a busy flag while programming runs.

Top module: `spiee_slave`

## Requirements
- R1: After reset, so_oe is low and req_valid is low.
- R2: Command bytes are taken MSB first on rising SCK. The upper nibble must be 0000. The low three bits select: 110 set enable, 100 clear enable, 101 status read, 001 status write, 011 array read, 010 page write. For the read and write commands, bit 3 is address bit 8. For the other four commands, bit 3 is ignored.
- R3: An array read sends the byte at {bit 3, address byte} MSB first on SO. SO changes on falling SCK. The address then steps by one per byte and wraps from 511 to 0 while CS_n stays low.
- R4: A page write posts a request of kind 3. The request carries req_addr equal to the address with its low three bits cleared, req_mask with bit k set for each page offset k that was received, and byte k at req_data[8k+7:8k].
- R5: During a page write only the low three address bits advance after each byte. A ninth or later byte overwrites the entry that was filled eight bytes earlier.
- R6: A request is posted only on a rising CS_n while SCK is low. For a page write, CS_n must also rise at a byte boundary after at least one data byte. Otherwise the transaction is discarded.
- R7: Set enable posts kind 0. Clear enable posts kind 1. Status write posts kind 2 with the data byte in req_data[7:0]. If WP_n is seen low at any point while CS_n is low, set enable, status write and page write post nothing. Clear enable still posts.
- R8: A status read shifts out stat_in, reloaded at the start of every byte, for as long as CS_n stays low.
- R9: After an unrecognised command byte, SO stays high impedance and no request is posted until CS_n rises and falls again.
- R10: While busy is high, every command except status read is treated as unrecognised.
- R11: While CS_n is low, HOLD_n low taken while SCK is low pauses the transfer. SO goes high impedance, SI and SCK edges are ignored, and the bit position is kept for resumption.
- R12: While CS_n is high, SI and SCK are ignored and so_oe is low.
- R13: A posted request holds req_valid and its payload stable until req_ready is high. A request that would be posted while one is still pending is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Bus chip select, active low |
| sck | input | 1 | Bus serial clock |
| si | input | 1 | Bus serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| wp_n | input | 1 | Write guard, active low |
| so | output | 1 | Serial data out (0 when not driven) |
| so_oe | output | 1 | Output enable for SO |
| rd_addr | output | 9 | Array read address |
| rd_data | input | 8 | Array read data, combinational from rd_addr |
| stat_in | input | 8 | Status byte from the controller |
| busy | input | 1 | Controller is programming |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Controller accepts the request |
| req_kind | output | 2 | 0 set enable, 1 clear enable, 2 status write, 3 page write |
| req_addr | output | 9 | Page base address |
| req_mask | output | 8 | Received page offsets |
| req_data | output | 64 | Page bytes, byte k at bits 8k+7:8k |

## Verification
Some properties are checked on every cycle: the request payload is held stable under back-pressure, a page request is shaped as a page, the upper address bits stay frozen during a page write, the unrecognised-command state is absorbing, busy gates the decoder, the bit counter and SO are frozen during a pause, and SO stays quiet while deselected. The mask in the page buffer is also checked to only grow until it is cleared. Other behaviour can only be shown by the bench scenarios. These cover read data and address wrap across the whole array, byte placement and overwrite when a page write runs past eight bytes, and whether a request is posted or discarded for each CS_n timing and write-guard case. They also cover status streaming and the resumption of a byte that was interrupted by a pause.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
    parameter int ADDR_W     = 9;
    parameter int PAGE_BYTES = 8;
    parameter int BYTE_W     = 8;
    localparam int PG_W      = $clog2(PAGE_BYTES);
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int PDATA_W   = PAGE_BYTES * BYTE_W;

    localparam logic [2:0] OPL_WEN_SET = 3'b110;
    localparam logic [2:0] OPL_WEN_CLR = 3'b100;
    localparam logic [2:0] OPL_ST_RD   = 3'b101;
    localparam logic [2:0] OPL_ST_WR   = 3'b001;
    localparam logic [2:0] OPL_ARR_RD  = 3'b011;
    localparam logic [2:0] OPL_ARR_WR  = 3'b010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_WR,
        ST_SOUT, ST_SIN, ST_SEND, ST_WEN, ST_WDI, ST_DEAD
    } st_e;

    typedef enum logic [1:0] {
        RQ_WEN_SET = 2'd0,
        RQ_WEN_CLR = 2'd1,
        RQ_STAT    = 2'd2,
        RQ_PAGE    = 2'd3
    } rq_e;
endpackage

// File: rtl/spiee_sync.sv
module spiee_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spiee_pagebuf.sv
module spiee_pagebuf
    import spiee_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [PG_W-1:0]       wofs,
    input  logic [BYTE_W-1:0]     wbyte,
    output logic [PDATA_W-1:0]    data,
    output logic [PAGE_BYTES-1:0] mask
);
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_entry
        logic [BYTE_W-1:0] byte_d, byte_q;
        logic              vld_d, vld_q;

        always_comb begin
            byte_d = byte_q;
            vld_d  = vld_q;
            if (clr) begin
                vld_d = 1'b0;
            end else if (we && (wofs == PG_W'(b))) begin
                byte_d = wbyte;
                vld_d  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                byte_q <= byte_d;
                vld_q  <= vld_d;
            end
        end

        assign data[b*BYTE_W +: BYTE_W] = byte_q;
        assign mask[b]                  = vld_q;
    end

    // offsets only accumulate within one transaction
    assert_mask_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((~mask & $past(mask)) == '0));
endmodule

// File: rtl/spiee_slave.sv
module spiee_slave
    import spiee_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sck,
    input  logic                  si,
    input  logic                  hold_n,
    input  logic                  wp_n,
    output logic                  so,
    output logic                  so_oe,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic [BYTE_W-1:0]     rd_data,
    input  logic [BYTE_W-1:0]     stat_in,
    input  logic                  busy,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [1:0]            req_kind,
    output logic [ADDR_W-1:0]     req_addr,
    output logic [PAGE_BYTES-1:0] req_mask,
    output logic [PDATA_W-1:0]    req_data
);
    localparam int NSYNC = 5;

    typedef struct packed {
        st_e                  st;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_W-1:0]    sr;
        logic [ADDR_W-1:0]    addr;
        logic                 a8;
        logic                 is_rd;
        logic [BYTE_W-1:0]    ob;
        logic                 so;
        logic                 live;
        logic                 hold;
        logic                 wp_seen;
        logic                 sck_p;
        logic                 cs_p;
        logic                 req_valid;
        rq_e                  req_kind;
        logic [ADDR_W-1:0]    req_addr;
        logic [PAGE_BYTES-1:0] req_mask;
        logic [PDATA_W-1:0]   req_data;
    } eng_s;

    eng_s q, nx;

    logic [NSYNC-1:0] sy;
    logic cs_n_s, hold_n_s, wp_n_s, sck_s, si_s;

    spiee_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, hold_n, wp_n, sck, si}),
        .dout (sy)
    );
    assign {cs_n_s, hold_n_s, wp_n_s, sck_s, si_s} = sy;

    logic                  pb_we, pb_clr;
    logic [PG_W-1:0]       pb_ofs;
    logic [BYTE_W-1:0]     pb_byte;
    logic [PDATA_W-1:0]    pb_data;
    logic [PAGE_BYTES-1:0] pb_mask;

    spiee_pagebuf u_page (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pb_clr),
        .we   (pb_we),
        .wofs (pb_ofs),
        .wbyte(pb_byte),
        .data (pb_data),
        .mask (pb_mask)
    );

    logic              sck_rise, sck_fall, cs_fall, cs_rise;
    logic              byte_end, can_post;
    logic [BYTE_W-1:0] sr_in, src_byte;

    always_comb begin
        nx       = q;
        sck_rise = sck_s & ~q.sck_p;
        sck_fall = ~sck_s & q.sck_p;
        cs_fall  = ~cs_n_s & q.cs_p;
        cs_rise  = cs_n_s & ~q.cs_p;
        sr_in    = {q.sr[BYTE_W-2:0], si_s};
        byte_end = (q.cnt == CNT_W'(BYTE_W - 1));
        can_post = !q.req_valid || req_ready;
        src_byte = (q.st == ST_RD) ? rd_data : stat_in;
        pb_we    = 1'b0;
        pb_clr   = 1'b0;
        pb_ofs   = q.addr[PG_W-1:0];
        pb_byte  = sr_in;
        nx.sck_p = sck_s;
        nx.cs_p  = cs_n_s;

        if (q.req_valid && req_ready) nx.req_valid = 1'b0;

        if (cs_n_s) begin
            // deselect: post whatever the transaction earned, then go idle
            if (cs_rise && !sck_s && can_post) begin
                case (q.st)
                    ST_WEN: if (!q.wp_seen) begin
                        nx.req_valid = 1'b1;
                        nx.req_kind  = RQ_WEN_SET;
                        nx.req_addr  = '0;
                        nx.req_mask  = '0;
                        nx.req_data  = '0;
                    end
                    ST_WDI: begin
                        nx.req_valid = 1'b1;
                        nx.req_kind  = RQ_WEN_CLR;
                        nx.req_addr  = '0;
                        nx.req_mask  = '0;
                        nx.req_data  = '0;
                    end
                    ST_SEND: if (!q.wp_seen) begin
                        nx.req_valid = 1'b1;
                        nx.req_kind  = RQ_STAT;
                        nx.req_addr  = '0;
                        nx.req_mask  = '0;
                        nx.req_data  = PDATA_W'(q.sr);
                    end
                    ST_WR: if (!q.wp_seen && (q.cnt == '0) && (pb_mask != '0)) begin
                        nx.req_valid = 1'b1;
                        nx.req_kind  = RQ_PAGE;
                        nx.req_addr  = {q.addr[ADDR_W-1:PG_W], {PG_W{1'b0}}};
                        nx.req_mask  = pb_mask;
                        nx.req_data  = pb_data;
                    end
                    default: ;
                endcase
            end
            nx.st   = ST_IDLE;
            nx.hold = 1'b0;
            nx.live = 1'b0;
        end else if (cs_fall) begin
            nx.st      = ST_OPC;
            nx.cnt     = '0;
            nx.live    = 1'b0;
            nx.hold    = 1'b0;
            nx.wp_seen = ~wp_n_s;
            pb_clr     = 1'b1;
        end else begin
            if (!wp_n_s) nx.wp_seen = 1'b1;
            if (!sck_s)  nx.hold    = ~hold_n_s;
            if (!q.hold && sck_rise) begin
                nx.sr  = sr_in;
                nx.cnt = q.cnt + 1'b1;
                if (byte_end) begin
                    case (q.st)
                        ST_OPC: begin
                            if (sr_in[7:4] != 4'b0000) begin
                                nx.st = ST_DEAD;
                            end else if (busy && (sr_in[2:0] != OPL_ST_RD)) begin
                                nx.st = ST_DEAD;
                            end else begin
                                case (sr_in[2:0])
                                    OPL_WEN_SET: nx.st = ST_WEN;
                                    OPL_WEN_CLR: nx.st = ST_WDI;
                                    OPL_ST_RD:   nx.st = ST_SOUT;
                                    OPL_ST_WR:   nx.st = ST_SIN;
                                    OPL_ARR_RD: begin
                                        nx.st    = ST_ADDR;
                                        nx.is_rd = 1'b1;
                                        nx.a8    = sr_in[3];
                                    end
                                    OPL_ARR_WR: begin
                                        nx.st    = ST_ADDR;
                                        nx.is_rd = 1'b0;
                                        nx.a8    = sr_in[3];
                                    end
                                    default:     nx.st = ST_DEAD;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            nx.addr = {q.a8, sr_in};
                            nx.st   = q.is_rd ? ST_RD : ST_WR;
                        end
                        ST_RD:  nx.addr = q.addr + 1'b1;
                        ST_WR: begin
                            pb_we                 = 1'b1;
                            nx.addr[PG_W-1:0]     = q.addr[PG_W-1:0] + 1'b1;
                        end
                        ST_SIN: nx.st = ST_SEND;
                        default: ;
                    endcase
                end
            end else if (!q.hold && sck_fall && ((q.st == ST_RD) || (q.st == ST_SOUT))) begin
                nx.live = 1'b1;
                if (q.cnt == '0) begin
                    nx.ob = src_byte;
                    nx.so = src_byte[BYTE_W-1];
                end else begin
                    nx.so = q.ob[CNT_W'(BYTE_W - 1) - q.cnt];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_p <= 1'b1;
        end else begin
            q <= nx;
        end
    end

    assign so_oe     = q.live & ~q.hold;
    assign so        = q.so & so_oe;
    assign rd_addr   = q.addr;
    assign req_valid = q.req_valid;
    assign req_kind  = q.req_kind;
    assign req_addr  = q.req_addr;
    assign req_mask  = q.req_mask;
    assign req_data  = q.req_data;

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req_valid && !req_ready) |=> (q.req_valid && $stable(q.req_kind) &&
        $stable(q.req_addr) && $stable(q.req_mask) && $stable(q.req_data)));

    assert_page_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req_valid && (q.req_kind == RQ_PAGE)) |->
        ((q.req_addr[PG_W-1:0] == '0) && (q.req_mask != '0)));

    assert_page_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR) |=> $stable(q.addr[ADDR_W-1:PG_W]));

    assert_dead_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEAD) |=> ((q.st == ST_DEAD) || (q.st == ST_IDLE)));

    assert_busy_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_OPC) && busy && !cs_n_s) |=>
        !((q.st == ST_ADDR) || (q.st == ST_WEN) || (q.st == ST_WDI) || (q.st == ST_SIN)));

    assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold |=> ($stable(q.cnt) && $stable(q.so)));

    assert_quiet_desel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n_s) && cs_n_s) |-> !so_oe);

    assert_oe_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> ((q.st == ST_RD) || (q.st == ST_SOUT)));
endmodule

// File: tb/tb_spiee_slave.sv
`timescale 1ns/1ps
module tb_spiee_slave;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;
    logic [8:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [7:0]  stat_in = 8'h0C;
    logic        busy = 1'b0;
    logic        req_valid, req_ready = 1'b1;
    logic [1:0]  req_kind;
    logic [8:0]  req_addr;
    logic [7:0]  req_mask;
    logic [63:0] req_data;

    logic [7:0]  mem [512];
    int          total = 0, bad = 0, nreq = 0;
    logic [1:0]  lk;
    logic [8:0]  la;
    logic [7:0]  lm;
    logic [63:0] ld;

    always #2 clk = ~clk;

    spiee_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe),
        .rd_addr(rd_addr), .rd_data(rd_data), .stat_in(stat_in), .busy(busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_mask(req_mask), .req_data(req_data)
    );

    assign rd_data = mem[rd_addr];

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 13) + (i >> 8) * 91 + 5);
    endfunction

    // controller model: owns the array, applies accepted page writes
    initial begin
        for (int i = 0; i < 512; i++) mem[i] = init_val(i);
        forever begin
            @(negedge clk);
            if (req_valid && req_ready) begin
                nreq++;
                lk = req_kind; la = req_addr; lm = req_mask; ld = req_data;
                if (req_kind == 2'd3)
                    for (int k = 0; k < 8; k++)
                        if (req_mask[k]) mem[{req_addr[8:3], 3'(k)}] = req_data[8*k +: 8];
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r);
        si = b;
        tick(HALF);
        r = so;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            sbit(t[i], b);
            r[i] = b;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_high();
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic set_ready(logic v);
        @(posedge clk);
        #1 req_ready = v;
    endtask

    initial begin
        #(4 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic        b;
        int          n0;
        logic [63:0] exp;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        check("R1 so_oe", 64'(so_oe), 64'd0);
        check("R1 req_valid", 64'(req_valid), 64'd0);

        // R3 sweep: whole array plus wrap, one continuous read
        cs_low();
        sbyte(8'h03, r);
        sbyte(8'h00, r);
        for (int k = 0; k < 514; k++) begin
            sbyte(8'h00, r);
            check("R3 sweep", 64'(r), 64'(init_val(k % 512)));
        end
        check("R3 so_oe during read", 64'(so_oe), 64'd1);
        cs_high();
        check("R12 so_oe after deselect", 64'(so_oe), 64'd0);

        // R2 upper address bit carried in command
        cs_low(); sbyte(8'h0B, r); sbyte(8'hA5, r); sbyte(8'h00, r); cs_high();
        check("R2 read 0x1A5", 64'(r), 64'(mem[9'h1A5]));

        // R3 wrap from top
        cs_low(); sbyte(8'h0B, r); sbyte(8'hFF, r);
        sbyte(8'h00, r); check("R3 top byte", 64'(r), 64'(mem[511]));
        sbyte(8'h00, r); check("R3 wrapped to 0", 64'(r), 64'(mem[0]));
        cs_high();

        // R4 short page write at 0x10D
        n0 = nreq;
        cs_low(); sbyte(8'h0A, r); sbyte(8'h0D, r);
        sbyte(8'h11, r); sbyte(8'h22, r); sbyte(8'h33, r); cs_high();
        check("R4 request posted", 64'(nreq - n0), 64'd1);
        check("R4 kind", 64'(lk), 64'd3);
        check("R4 base", 64'(la), 64'h108);
        check("R4 mask", 64'(lm), 64'hE0);
        check("R4 data", 64'(ld[63:40]), 64'h332211);

        // R5 ten bytes from offset 6 wrap within the page
        exp = '0;
        cs_low(); sbyte(8'h02, r); sbyte(8'hF6, r);
        for (int j = 0; j < 10; j++) begin
            sbyte(8'(8'hA0 + j), r);
            exp[8*((6 + j) % 8) +: 8] = 8'(8'hA0 + j);
        end
        cs_high();
        check("R5 base", 64'(la), 64'h0F0);
        check("R5 mask", 64'(lm), 64'hFF);
        check("R5 data", ld, exp);

        // R6 partial byte at deselect
        n0 = nreq;
        cs_low(); sbyte(8'h02, r); sbyte(8'h20, r); sbyte(8'h55, r);
        sbit(1'b1, b); sbit(1'b0, b); sbit(1'b1, b); cs_high();
        check("R6 partial byte dropped", 64'(nreq - n0), 64'd0);
        // R6 deselect while SCK high after last bit
        cs_low(); sbyte(8'h02, r); sbyte(8'h20, r);
        for (int i = 7; i >= 1; i--) sbit(i[0], b);
        si = 1'b0; tick(HALF); sck = 1'b1; tick(HALF);
        cs_n = 1'b1; tick(HALF); sck = 1'b0; tick(3 * HALF);
        check("R6 SCK high at deselect dropped", 64'(nreq - n0), 64'd0);
        // R6 address only, no data
        cs_low(); sbyte(8'h02, r); sbyte(8'h20, r); cs_high();
        check("R6 no data byte dropped", 64'(nreq - n0), 64'd0);

        // R7 enable / status commands
        n0 = nreq;
        cs_low(); sbyte(8'h06, r); cs_high();
        check("R7 set enable", 64'({lk, 2'(nreq - n0)}), 64'({2'd0, 2'd1}));
        cs_low(); sbyte(8'h0E, r); cs_high();
        check("R7 set enable bit3 ignored", 64'({lk, 2'(nreq - n0)}), 64'({2'd0, 2'd2}));
        cs_low(); sbyte(8'h04, r); cs_high();
        check("R7 clear enable", 64'({lk, 2'(nreq - n0)}), 64'({2'd1, 2'd3}));
        cs_low(); sbyte(8'h01, r); sbyte(8'h8C, r); cs_high();
        check("R7 status write", 64'({lk, ld[7:0]}), 64'({2'd2, 8'h8C}));
        wp_n = 1'b0;
        n0 = nreq;
        cs_low(); sbyte(8'h06, r); cs_high();
        cs_low(); sbyte(8'h01, r); sbyte(8'h80, r); cs_high();
        cs_low(); sbyte(8'h02, r); sbyte(8'h30, r); sbyte(8'h77, r); cs_high();
        check("R7 guarded writes dropped", 64'(nreq - n0), 64'd0);
        cs_low(); sbyte(8'h04, r); cs_high();
        check("R7 clear passes guard", 64'({lk, 2'(nreq - n0)}), 64'({2'd1, 2'd1}));
        wp_n = 1'b1;
        // guard pulse mid-transaction
        n0 = nreq;
        cs_low(); sbyte(8'h02, r); wp_n = 1'b0; tick(HALF); wp_n = 1'b1;
        sbyte(8'h30, r); sbyte(8'h77, r); cs_high();
        check("R7 guard pulse drops page", 64'(nreq - n0), 64'd0);

        // R8 status stream, reloaded each byte
        stat_in = 8'h3C;
        cs_low(); sbyte(8'h05, r);
        sbyte(8'h00, r); check("R8 status first", 64'(r), 64'h3C);
        stat_in = 8'hA6;
        sbyte(8'h00, r); check("R8 status reloaded", 64'(r), 64'hA6);
        cs_high();

        // R9 unrecognised commands
        n0 = nreq;
        cs_low(); sbyte(8'h13, r); sbyte(8'h06, r); sbyte(8'h00, r);
        check("R9 upper nibble so_oe", 64'(so_oe), 64'd0);
        cs_high();
        cs_low(); sbyte(8'h07, r); sbyte(8'h02, r); sbyte(8'h00, r); sbyte(8'h11, r);
        check("R9 code 111 so_oe", 64'(so_oe), 64'd0);
        cs_high();
        check("R9 no request", 64'(nreq - n0), 64'd0);

        // R10 busy
        busy = 1'b1;
        n0 = nreq;
        cs_low(); sbyte(8'h06, r); cs_high();
        cs_low(); sbyte(8'h03, r); sbyte(8'h10, r); sbyte(8'h00, r);
        check("R10 read refused", 64'(so_oe), 64'd0);
        cs_high();
        check("R10 no request", 64'(nreq - n0), 64'd0);
        stat_in = 8'hFF;
        cs_low(); sbyte(8'h05, r); sbyte(8'h00, r); cs_high();
        check("R10 status read allowed", 64'(r), 64'hFF);
        busy = 1'b0;

        // R11 pause in a read
        cs_low(); sbyte(8'h03, r); sbyte(8'h20, r);
        for (int i = 7; i >= 5; i--) begin sbit(1'b0, b); r[i] = b; end
        hold_n = 1'b0; tick(HALF);
        check("R11 so hi-z in pause", 64'(so_oe), 64'd0);
        for (int i = 0; i < 5; i++) begin
            si = i[0]; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1; tick(HALF);
        for (int i = 4; i >= 0; i--) begin sbit(1'b0, b); r[i] = b; end
        check("R11 resumed byte", 64'(r), 64'(mem[9'h020]));
        sbyte(8'h00, r);
        check("R11 next byte", 64'(r), 64'(mem[9'h021]));
        cs_high();
        // R11 pause in a page write
        n0 = nreq;
        cs_low(); sbyte(8'h02, r); sbyte(8'h40, r);
        sbit(1'b1, b); sbit(1'b1, b); sbit(1'b0, b); sbit(1'b0, b);
        hold_n = 1'b0; tick(HALF);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1; tick(HALF);
        sbit(1'b0, b); sbit(1'b0, b); sbit(1'b1, b); sbit(1'b1, b);
        cs_high();
        check("R11 write after pause", 64'({2'(nreq - n0), lm, ld[7:0]}),
              64'({2'd1, 8'h01, 8'hC3}));

        // R12 traffic while deselected
        n0 = nreq;
        for (int i = 0; i < 16; i++) begin
            si = (i % 8 == 5) || (i % 8 == 6); sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        check("R12 no request", 64'(nreq - n0), 64'd0);
        check("R12 so_oe", 64'(so_oe), 64'd0);
        cs_low(); sbyte(8'h0B, r); sbyte(8'h00, r); sbyte(8'h00, r); cs_high();
        check("R12 clean read afterwards", 64'(r), 64'(mem[9'h100]));

        // R13 back-pressure
        set_ready(1'b0);
        n0 = nreq;
        cs_low(); sbyte(8'h04, r); cs_high();
        check("R13 valid held", 64'({req_valid, req_kind}), 64'({1'b1, 2'd1}));
        cs_low(); sbyte(8'h06, r); cs_high();
        tick(10);
        check("R13 pending kept", 64'({req_valid, req_kind}), 64'({1'b1, 2'd1}));
        set_ready(1'b1);
        tick(3);
        check("R13 accepted once", 64'({req_valid, 2'(nreq - n0)}), 64'({1'b0, 2'd1}));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule